// File: doc/BRIEF.md
# SD Host Error Interrupt Status

This block gathers error events from the command and data paths of an SD/MMC host and holds them in a 16-bit sticky status word. Every event is a one-cycle pulse. It latches into its status bit only when the matching bit of a status-enable mask is set. A second mask, the signal-enable mask, picks which latched bits drive the single error interrupt output. It has no effect on latching.

Software reaches three registers through a simple write/read port: the status word, the status-enable mask and the signal-enable mask. A status bit is cleared by writing 1 to it, and several bits can be cleared in one write. The auto stop-command error bit is not set by a pulse. It is set when any bit of a separate auto stop-command error word goes from 0 to 1. The block detects this by comparing the word with a registered copy of itself on every clock.

Top module: `sd_err_irq_status`

## Requirements
- R1: A status bit latches an event only when its status-enable bit is 1. With that enable bit at 0, the event leaves the status bit at 0.
- R2: `err_irq` is high exactly when some status bit and its signal-enable bit are both 1. The signal-enable mask has no effect on whether a status bit latches.
- R3: A write to the status register clears every bit written as 1 and leaves every bit written as 0 unchanged. Several bits can be cleared in one write.
- R4: After reset, all three registers read 0x0000. In all three registers, bits [15:9] and bit 7 always read 0.
- R5: Status bit positions are: 0 command timeout, 1 command CRC error, 2 command end-bit error, 3 command index error, 5 data CRC error, 6 data end-bit error.
- R6: Status bit 4 (data timeout) sets when any of the four `dat_timeout` sources pulses.
- R7: Status bit 8 sets in the cycle after any bit of `astop_err_word` changes from 0 to 1. A word that holds its value, or a bit that falls from 1 to 0, does not set it.
- R8: When a set event and a write-1-clear reach the same bit in the same cycle, the bit ends up 1.
- R9: `bus_addr` selects the register: 0 is status, 1 is status-enable, 2 is signal-enable, and 3 reads 0. Reads are combinational.
- R10: With no event and no write, the status word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| cmd_timeout | input | 1 | Command timeout pulse |
| cmd_crc_err | input | 1 | Command CRC error pulse |
| cmd_endbit_err | input | 1 | Command end-bit error pulse |
| cmd_index_err | input | 1 | Command index error pulse |
| dat_timeout | input | 4 | Four data timeout source pulses |
| dat_crc_err | input | 1 | Data CRC error pulse |
| dat_endbit_err | input | 1 | Data end-bit error pulse |
| astop_err_word | input | ASTOP_W | Auto stop-command error status word |
| err_irq | output | 1 | Error interrupt |

## Verification
A wrong status bit appears on `bus_rdata` at address 0 on the first read after the faulty edge. It appears on `err_irq` in that same cycle if the bit's signal-enable bit is set. A stale copy of the auto stop word shows as a missing set on a rising bit, or as a spurious set on a held word or a falling bit, one cycle after the change. Mask storage faults show up in two ways: as events latched while the enable bit is off, or as an interrupt that does not follow the signal mask as soon as it is written.

// File: rtl/sd_err_irq_status.sv
module sd_err_irq_status #(
  parameter int ASTOP_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [1:0]         bus_addr,
  input  logic [15:0]        bus_wdata,
  output logic [15:0]        bus_rdata,
  input  logic               cmd_timeout,
  input  logic               cmd_crc_err,
  input  logic               cmd_endbit_err,
  input  logic               cmd_index_err,
  input  logic [3:0]         dat_timeout,
  input  logic               dat_crc_err,
  input  logic               dat_endbit_err,
  input  logic [ASTOP_W-1:0] astop_err_word,
  output logic               err_irq
);
  localparam logic [15:0] LIVE = 16'h017F;

  logic [15:0]        sts, sts_en, sig_en;
  logic [ASTOP_W-1:0] astop_q;
  logic               astop_rise;
  logic [15:0]        raw, set, clr;

  assign astop_rise = |(astop_err_word & ~astop_q);
  assign raw = {7'b0, astop_rise, 1'b0, dat_endbit_err, dat_crc_err, |dat_timeout,
                cmd_index_err, cmd_endbit_err, cmd_crc_err, cmd_timeout};
  assign set = raw & sts_en;
  assign clr = (bus_wr && bus_addr == 2'd0) ? bus_wdata : 16'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts     <= '0;
      sts_en  <= '0;
      sig_en  <= '0;
      astop_q <= '0;
    end else begin
      astop_q <= astop_err_word;
      sts     <= ((sts & ~clr) | set) & LIVE;
      if (bus_wr && bus_addr == 2'd1) sts_en <= bus_wdata & LIVE;
      if (bus_wr && bus_addr == 2'd2) sig_en <= bus_wdata & LIVE;
    end
  end

  assign err_irq = |(sts & sig_en);

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = sts;
      2'd1:    bus_rdata = sts_en;
      2'd2:    bus_rdata = sig_en;
      default: bus_rdata = 16'h0;
    endcase
  end

  a_r1_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (sts & ~$past(sts) & ~$past(sts_en)) == 16'h0);

  a_r2_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> (sts != 16'h0));

  a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_wr && bus_addr == 2'd0) |-> ((sts & $past(bus_wdata & ~set)) == 16'h0));

  a_r7_astop_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $past(astop_rise && sts_en[8]) |-> sts[8]);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts & $past(set)) == $past(set)));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr) == 16'h0 && $past(set) == 16'h0) |-> $stable(sts));
endmodule

// File: tb/sd_err_irq_status_tb.sv
module sd_err_irq_status_tb;
  logic        clk = 0, rst_n = 0;
  logic        bus_wr = 0;
  logic [1:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic        cmd_timeout = 0, cmd_crc_err = 0, cmd_endbit_err = 0, cmd_index_err = 0;
  logic [3:0]  dat_timeout = 0;
  logic        dat_crc_err = 0, dat_endbit_err = 0;
  logic [4:0]  astop_err_word = 0;
  logic        err_irq;

  always #10 clk = ~clk;

  sd_err_irq_status #(.ASTOP_W(5)) u_dut (.*);

  typedef struct { logic [1:0] a; logic [15:0] d; logic irq; string tag; } item_t;
  item_t q[$];
  event  chk_ev;
  int    n_vec = 0, n_bad = 0;
  bit    done = 0;

  logic [15:0] m_sts = 0, m_sen = 0, m_sig = 0;
  logic [4:0]  m_ast = 0;

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic step(input logic [6:0] ev, input logic [3:0] tmo, input logic [4:0] ast,
                      input logic wr, input logic [1:0] a, input logic [15:0] d);
    logic [15:0] raw, clr;
    cmd_timeout = ev[0]; cmd_crc_err = ev[1]; cmd_endbit_err = ev[2]; cmd_index_err = ev[3];
    dat_crc_err = ev[5]; dat_endbit_err = ev[6]; dat_timeout = tmo;
    astop_err_word = ast; bus_wr = wr; bus_addr = a; bus_wdata = d;
    raw = {7'b0, |(ast & ~m_ast), 1'b0, ev[6], ev[5], |tmo, ev[3:0]};
    clr = (wr && a == 0) ? d : 16'h0;
    m_sts = ((m_sts & ~clr) | (raw & m_sen)) & 16'h017F;
    if (wr && a == 1) m_sen = d & 16'h017F;
    if (wr && a == 2) m_sig = d & 16'h017F;
    m_ast = ast;
    tick();
    {cmd_timeout, cmd_crc_err, cmd_endbit_err, cmd_index_err, dat_crc_err, dat_endbit_err} = '0;
    dat_timeout = 0; bus_wr = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    step(7'h0, 4'h0, m_ast, 1'b1, a, d);
  endtask

  task automatic chk(input logic [1:0] a, input string tag);
    item_t it;
    logic [15:0] e;
    e = (a == 0) ? m_sts : (a == 1) ? m_sen : (a == 2) ? m_sig : 16'h0;
    it.a = a; it.d = e; it.irq = |(m_sts & m_sig); it.tag = tag;
    bus_addr = a;
    q.push_back(it);
    #2 -> chk_ev;
    #1;
  endtask

  always begin
    @(chk_ev);
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_vec++;
      if (bus_rdata !== it.d || err_irq !== it.irq) begin
        n_bad++;
        $display("FAIL %s addr=%0d: rdata=%h irq=%b expected rdata=%h irq=%b",
                 it.tag, it.a, bus_rdata, err_irq, it.d, it.irq);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    chk(0, "R4 reset status"); chk(1, "R4 reset sts_en"); chk(2, "R4 reset sig_en");
    wr(1, 16'hFFFF); chk(1, "R4 R9 sts_en reserved bits 0");
    wr(2, 16'hFF80); chk(2, "R4 R9 sig_en reserved bits 0");
    wr(2, 16'h0000);
    chk(3, "R9 addr 3 reads 0");
    // R5 layout, R2 latching independent of sig_en
    step(7'h01, 0, 0, 0, 0, 0); chk(0, "R5 R2 cmd timeout bit0");
    step(7'h02, 0, 0, 0, 0, 0); chk(0, "R5 cmd crc bit1");
    step(7'h04, 0, 0, 0, 0, 0); chk(0, "R5 cmd endbit bit2");
    step(7'h08, 0, 0, 0, 0, 0); chk(0, "R5 cmd index bit3");
    step(7'h20, 0, 0, 0, 0, 0); chk(0, "R5 dat crc bit5");
    step(7'h40, 0, 0, 0, 0, 0); chk(0, "R5 dat endbit bit6");
    // R10 sticky
    repeat (5) tick(); chk(0, "R10 status holds");
    // R3 write 0 keeps, multi clear
    wr(0, 16'h0000); chk(0, "R3 write 0 keeps");
    wr(0, 16'h0023); chk(0, "R3 multi clear");
    wr(0, 16'hFFFF); chk(0, "R3 clear all");
    // R6 each timeout source
    for (int i = 0; i < 4; i++) begin
      step(7'h0, 4'(1 << i), 0, 0, 0, 0); chk(0, $sformatf("R6 timeout src %0d", i));
      wr(0, 16'h0010); chk(0, "R6 cleared");
    end
    // R2 irq gating
    step(7'h0, 4'h2, 0, 0, 0, 0);
    chk(0, "R2 no irq with sig_en 0");
    wr(2, 16'h0001); chk(0, "R2 irq masked on other bit");
    wr(2, 16'h0010); chk(0, "R2 irq asserted");
    wr(0, 16'h0010); chk(0, "R2 irq drops after clear");
    // R1 enable gating
    wr(1, 16'h0001);
    step(7'h7F, 4'hF, 5'h1F, 0, 0, 0); chk(0, "R1 only enabled bit latches");
    wr(0, 16'hFFFF);
    step(7'h0, 0, 5'h00, 0, 0, 0);
    wr(1, 16'hFFFF);
    // R7 astop edges
    step(7'h0, 0, 5'h01, 0, 0, 0); chk(0, "R7 rise sets bit8");
    wr(0, 16'h0100); chk(0, "R7 cleared");
    step(7'h0, 0, 5'h01, 0, 0, 0); chk(0, "R7 held word no set");
    step(7'h0, 0, 5'h00, 0, 0, 0); chk(0, "R7 fall no set");
    step(7'h0, 0, 5'h06, 0, 0, 0); chk(0, "R7 multi-bit rise sets");
    step(7'h0, 0, 5'h07, 0, 0, 0); chk(0, "R7 added bit rise");
    // R8 set beats clear
    wr(0, 16'hFFFF);
    step(7'h20, 0, m_ast, 1, 0, 16'h0020); chk(0, "R8 set wins over clear");
    wr(0, 16'h0020); chk(0, "R8 then clears");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule